// File: doc/BRIEF.md
# Hash Engine Memory-Fetch Controller

This block is the control and data-movement front end of a memory-mapped SHA-256 accelerator. Software programs a small byte-wide register file with a base address, a block count and a command. The controller then takes over a 32-bit memory master port. It fetches whole 64-byte message blocks, turns each group of four bytes into a big-endian message word and passes each assembled block to an external compression core. Each block goes to the core together with the current chaining state over a start/done handshake. The core's result becomes the new chaining state.

A separate command stores the eight chaining words back to memory, so software can collect the digest. Message padding and the round function are outside this block. The busy flag covers every operation. On completion the block raises an interrupt-status flag, which software clears by writing 1 to it.

Top module: `hash_fetch_engine`

## Requirements
- R1: After reset, the control, status and count registers read 0x00, irq is 0, and the chaining state is all zero, so a write-back issued straight after reset stores eight zero words.
- R2: Writing the control register (offset 0x00) with bit 0 (execute) and bit 1 (initialise) both set loads the SHA-256 initial hash values 6a09e667, bb67ae85, 3c6ef372, a54ff53a, 510e527f, 9b05688c, 1f83d9ab, 5be0cd19 before the first block. The core sees these values as its state input, H0 in bits [255:224] and H7 in bits [31:0].
- R3: An execute command written without the initialise bit continues from the chaining state left by the previous operation.
- R4: A count value N in the register at offset 0x02 (4 bits) makes one execute process N+1 blocks. The reads go to base, base+4, base+8 and so on in strictly increasing order with no gaps: 16 word reads per block, and each block starts 64 bytes after the previous one.
- R5: The base address is {reg 0x06, reg 0x04, reg 0x03 bits [7:6], six zero bits}. Bits [5:0] of offset 0x03 are ignored and read back as zero.
- R6: A message word is built with the byte at the lowest address in bits [31:24]. Word 0 of a block sits in core_block[511:480] and word 15 in core_block[31:0]. The chaining state takes the core result when core_done is high.
- R7: Writing 1 to control bit 2 (with bit 0 clear) stores H0..H7 as eight word writes to base, base+4, ..., base+28. The word values are written unchanged.
- R8: Busy (status bit 0) is 1 from the cycle after an accepted command until the operation ends. A memory request is held with a stable address until it is acknowledged.
- R9: When an operation ends, interrupt status (status bit 2) is set. Writing 1 to that bit clears it, and writing 0 to it leaves it unchanged. irq equals interrupt status AND interrupt enable (status bit 3, read/write).
- R10: An execute or write-back command written while busy is ignored, and a count or base written while busy does not affect the running operation.
- R11: The algorithm-select register at offset 0x05 holds any 8-bit value written (0x00 selects SHA-256). The control register always reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt: status flag AND enable |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 24 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, little-endian, valid with mem_ack |
| mem_ack | input | 1 | Completes the current request |
| core_start | output | 1 | One-cycle start pulse to the compression core |
| core_state | output | 256 | Current chaining state, H0 in the top word |
| core_block | output | 512 | Assembled message block, word 0 in the top word |
| core_done | input | 1 | Core result valid, one cycle |
| core_result | input | 256 | New chaining state from the core |

## Verification
The assertions assume a well-behaved environment. mem_ack is only ever high while mem_req is high, and read data is valid in the same cycle. core_done arrives once for each core_start and only after it, and each register write lasts one cycle. The bench's memory model acknowledges on alternating cycles, so every request sees both a held phase and a completion phase. Its core model answers three cycles after each start, which is always after the pulse has ended. Register writes come from a task that raises the strobe for exactly one clock.

// File: rtl/hfe_pkg.sv
// Shared constants, types and helpers for the hash fetch engine.
// Assumes a 24-bit byte address built from three byte registers.
package hfe_pkg;
    localparam int ADDR_W   = 24;
    localparam int WORD_W   = 32;
    localparam int ST_WORDS = 8;
    localparam int ST_W     = ST_WORDS * WORD_W;
    localparam int SW_W     = $clog2(ST_WORDS);

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CNT  = 3'd2;
    localparam logic [2:0] OFS_BLO  = 3'd3;
    localparam logic [2:0] OFS_BMID = 3'd4;
    localparam logic [2:0] OFS_ALG  = 3'd5;
    localparam logic [2:0] OFS_BHI  = 3'd6;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_KICK, S_WAIT, S_WBACK
    } seq_st_t;

    // SHA-256 initial chaining values, H0 in the most significant word.
    function automatic logic [ST_W-1:0] iv_state();
        return {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    endfunction

    // Reorders a little-endian memory word into a big-endian message word.
    function automatic logic [WORD_W-1:0] be_word(input logic [WORD_W-1:0] le);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W/8; b++)
            r[WORD_W-1-8*b -: 8] = le[8*b +: 8];
        return r;
    endfunction
endpackage

// File: rtl/hfe_regs.sv
// Byte-wide register file: command decode, count, base address,
// algorithm select, interrupt status/enable and the irq output.
// Assumes reg_we is a single-cycle strobe and CNT_W <= 8.
module hfe_regs
    import hfe_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy,
    input  logic              op_done,
    output logic              go_exec,
    output logic              go_init,
    output logic              go_wb,
    output logic [CNT_W-1:0]  blk_cnt,
    output logic [ADDR_W-1:0] base_addr,
    output logic              irq
);
    logic             int_en, int_stat;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       algo_q, bmid_q, bhi_q;
    logic [1:0]       blo_q;
    logic             wr_ctrl, wr_stat;

    // Decode writes to the command and status registers.
    always_comb begin
        wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
        wr_stat = reg_we && (reg_addr == OFS_STAT);
    end

    // Commands are accepted only while the sequencer is idle.
    always_comb begin
        go_exec = wr_ctrl && reg_wdata[0] && !busy;
        go_init = reg_wdata[1];
        go_wb   = wr_ctrl && reg_wdata[2] && !reg_wdata[0] && !busy;
    end

    // Holding registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en <= 1'b0;
            cnt_q  <= '0;
            algo_q <= 8'h00;
            blo_q  <= 2'b00;
            bmid_q <= 8'h00;
            bhi_q  <= 8'h00;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_STAT: int_en <= reg_wdata[3];
                OFS_CNT:  cnt_q  <= reg_wdata[CNT_W-1:0];
                OFS_BLO:  blo_q  <= reg_wdata[7:6];
                OFS_BMID: bmid_q <= reg_wdata;
                OFS_ALG:  algo_q <= reg_wdata;
                OFS_BHI:  bhi_q  <= reg_wdata;
                default:  ;
            endcase
        end
    end

    // Interrupt status: completion sets it, a written 1 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                      int_stat <= 1'b0;
        else if (op_done)                int_stat <= 1'b1;
        else if (wr_stat && reg_wdata[2]) int_stat <= 1'b0;
    end

    // Readback multiplexer and derived outputs.
    always_comb begin
        case (reg_addr)
            OFS_STAT: reg_rdata = {4'b0, int_en, int_stat, 1'b0, busy};
            OFS_CNT:  reg_rdata = 8'(cnt_q);
            OFS_BLO:  reg_rdata = {blo_q, 6'b0};
            OFS_BMID: reg_rdata = bmid_q;
            OFS_ALG:  reg_rdata = algo_q;
            OFS_BHI:  reg_rdata = bhi_q;
            default:  reg_rdata = 8'h00;
        endcase
        blk_cnt   = cnt_q;
        base_addr = {bhi_q, bmid_q, blo_q, 6'b0};
        irq       = int_stat && int_en;
    end

    a_r9_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (reg_addr != OFS_STAT) || reg_rdata[2]);
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        int_stat && !(wr_stat && reg_wdata[2]) |=> int_stat);
endmodule

// File: rtl/hfe_assemble.sv
// Message block assembler: shifts in byte-reordered words so that the
// first word fetched ends up in the top word of the block.
// Assumes exactly BLK_WORDS captures per block before the core starts.
module hfe_assemble
    import hfe_pkg::*;
#(
    parameter int BLK_WORDS = 16,
    localparam int BLK_W = BLK_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [WORD_W-1:0] mem_word,
    output logic [BLK_W-1:0]  block
);
    logic [BLK_W-1:0] blk_q;

    // Shift the newest big-endian word into the low end of the block.
    always_ff @(posedge clk) begin
        if (!rst_n)      blk_q <= '0;
        else if (cap_en) blk_q <= {blk_q[BLK_W-WORD_W-1:0], be_word(mem_word)};
    end

    assign block = blk_q;

    a_r6_byte_order: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> block[7:0] == $past(mem_word[31:24]) &&
                   block[31:24] == $past(mem_word[7:0]));
endmodule

// File: rtl/hfe_seq.sv
// Operation sequencer: owns the memory port during fetch and write-back,
// keeps the chaining state, and runs the start/done handshake with the core.
// Assumes mem_ack only while mem_req, and one core_done per core_start.
module hfe_seq
    import hfe_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int BLK_WORDS = 16,
    localparam int IDX_W     = $clog2(BLK_WORDS),
    localparam int BLK_BYTES = BLK_WORDS * (WORD_W/8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_exec,
    input  logic              go_init,
    input  logic              go_wb,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [ADDR_W-1:0] base_in,
    output logic              busy,
    output logic              op_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic              cap_en,
    output logic              core_start,
    output logic [ST_W-1:0]   core_state,
    input  logic              core_done,
    input  logic [ST_W-1:0]   core_result
);
    seq_st_t           st;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  blk, blk_last;
    logic [ADDR_W-1:0] cur_addr;
    logic [ST_W-1:0]   chain;
    logic              last_word, last_blk, last_wb;

    // Terminal conditions for word, block and write-back counting.
    always_comb begin
        last_word = (idx == IDX_W'(BLK_WORDS-1));
        last_blk  = (blk == blk_last);
        last_wb   = (idx == IDX_W'(ST_WORDS-1));
    end

    // Main state machine with the latched operation parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            idx      <= '0;
            blk      <= '0;
            blk_last <= '0;
            cur_addr <= '0;
            chain    <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (go_exec) begin
                        blk_last <= cnt_in;
                        blk      <= '0;
                        idx      <= '0;
                        cur_addr <= base_in;
                        if (go_init) chain <= iv_state();
                        st <= S_FETCH;
                    end else if (go_wb) begin
                        idx      <= '0;
                        cur_addr <= base_in;
                        st       <= S_WBACK;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        idx <= last_word ? '0 : idx + 1'b1;
                        if (last_word) st <= S_KICK;
                    end
                end
                S_KICK: st <= S_WAIT;
                S_WAIT: begin
                    if (core_done) begin
                        chain <= core_result;
                        if (last_blk) begin
                            st <= S_IDLE;
                        end else begin
                            blk      <= blk + 1'b1;
                            cur_addr <= cur_addr + ADDR_W'(BLK_BYTES);
                            st       <= S_FETCH;
                        end
                    end
                end
                S_WBACK: begin
                    if (mem_ack) begin
                        idx <= last_wb ? '0 : idx + 1'b1;
                        if (last_wb) st <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Port drive derived from the current state.
    always_comb begin
        busy       = (st != S_IDLE);
        mem_req    = (st == S_FETCH) || (st == S_WBACK);
        mem_we     = (st == S_WBACK);
        mem_addr   = cur_addr + ADDR_W'({idx, 2'b00});
        mem_wdata  = chain[(ST_WORDS-1-int'(idx[SW_W-1:0]))*WORD_W +: WORD_W];
        cap_en     = (st == S_FETCH) && mem_ack;
        core_start = (st == S_KICK);
        core_state = chain;
        op_done    = ((st == S_WAIT) && core_done && last_blk) ||
                     ((st == S_WBACK) && mem_ack && last_wb);
    end

    a_r10_cmd_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (go_exec || go_wb) |-> !busy);
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FETCH) && mem_ack && !last_word |=> mem_addr == $past(mem_addr) + 24'd4);
    a_r2_iv_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        go_exec && go_init |=> core_state == iv_state());
    a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start && busy);
endmodule

// File: rtl/hash_fetch_engine.sv
// Top of the hash engine front end: register file, sequencer and block
// assembler. The round function sits outside, behind core_start/core_done.
// Assumes a memory that returns little-endian words together with mem_ack.
module hash_fetch_engine
    import hfe_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int BLK_WORDS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [2:0]                  reg_addr,
    input  logic [7:0]                  reg_wdata,
    output logic [7:0]                  reg_rdata,
    output logic                        irq,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [23:0]                 mem_addr,
    output logic [31:0]                 mem_wdata,
    input  logic [31:0]                 mem_rdata,
    input  logic                        mem_ack,
    output logic                        core_start,
    output logic [255:0]                core_state,
    output logic [BLK_WORDS*32-1:0]     core_block,
    input  logic                        core_done,
    input  logic [255:0]                core_result
);
    logic              busy, op_done, go_exec, go_init, go_wb, cap_en;
    logic [CNT_W-1:0]  blk_cnt;
    logic [ADDR_W-1:0] base_addr;

    hfe_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .op_done(op_done), .go_exec(go_exec), .go_init(go_init), .go_wb(go_wb),
        .blk_cnt(blk_cnt), .base_addr(base_addr), .irq(irq)
    );

    hfe_seq #(.CNT_W(CNT_W), .BLK_WORDS(BLK_WORDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_exec(go_exec), .go_init(go_init),
        .go_wb(go_wb), .cnt_in(blk_cnt), .base_in(base_addr), .busy(busy),
        .op_done(op_done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .cap_en(cap_en), .core_start(core_start), .core_state(core_state),
        .core_done(core_done), .core_result(core_result)
    );

    hfe_assemble #(.BLK_WORDS(BLK_WORDS)) u_asm (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mem_word(mem_rdata),
        .block(core_block)
    );

    a_r8_port_owned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> reg_rdata[0] || reg_addr != OFS_STAT);
endmodule

// File: tb/sim_hash_fetch_engine.sv
module sim_hash_fetch_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [7:0]   reg_wdata = 8'h00;
    logic [7:0]   reg_rdata;
    logic         irq, mem_req, mem_we, mem_ack, core_start;
    logic [23:0]  mem_addr;
    logic [31:0]  mem_wdata, mem_rdata;
    logic [255:0] core_state, core_result;
    logic [511:0] core_block;
    logic         core_done;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    hash_fetch_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .core_start(core_start), .core_state(core_state), .core_block(core_block),
        .core_done(core_done), .core_result(core_result)
    );

    // ---------------- memory model: 4 KiB, ack on alternate cycles
    logic [7:0]  mem [4096];
    logic        ack_t;
    logic [23:0] rd_log [2048];
    int          rd_n;
    wire  [11:0] ma = {mem_addr[11:2], 2'b00};
    assign mem_ack   = mem_req & ack_t;
    assign mem_rdata = {mem[ma+3], mem[ma+2], mem[ma+1], mem[ma]};

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_t <= 1'b0;
            rd_n  <= 0;
        end else begin
            ack_t <= ~ack_t;
            if (mem_req && mem_ack && mem_we) begin
                mem[ma]   = mem_wdata[7:0];
                mem[ma+1] = mem_wdata[15:8];
                mem[ma+2] = mem_wdata[23:16];
                mem[ma+3] = mem_wdata[31:24];
            end
            if (mem_req && mem_ack && !mem_we) begin
                rd_log[rd_n % 2048] <= mem_addr;
                rd_n <= rd_n + 1;
            end
        end
    end

    // ---------------- compression core model: answers 3 cycles after start
    function automatic logic [255:0] core_fn(input logic [255:0] s, input logic [511:0] b);
        logic [255:0] r;
        for (int i = 0; i < 8; i++)
            r[255-32*i -: 32] = s[255-32*i -: 32] + (b[511-32*i -: 32] ^ b[511-32*(i+8) -: 32]);
        return r;
    endfunction

    logic [255:0] c_st, st_log [64];
    logic [511:0] c_blk;
    logic         c_pend;
    int           c_cnt, n_start;
    always @(posedge clk) begin
        if (!rst_n) begin
            core_done <= 1'b0; core_result <= '0; c_pend <= 1'b0;
            c_cnt <= 0; n_start <= 0;
        end else begin
            core_done <= 1'b0;
            if (core_start) begin
                c_st <= core_state; c_blk <= core_block; c_cnt <= 3; c_pend <= 1'b1;
                st_log[n_start % 64] <= core_state;
                n_start <= n_start + 1;
            end else if (c_pend) begin
                if (c_cnt == 1) begin
                    core_done <= 1'b1; core_result <= core_fn(c_st, c_blk); c_pend <= 1'b0;
                end
                c_cnt <= c_cnt - 1;
            end
        end
    end

    // ---------------- expected model (from the requirements)
    logic [31:0] exp_h [8];
    function automatic logic [31:0] msg_word(input int a);
        return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
    endfunction
    function automatic logic [255:0] pack_h();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[255-32*i -: 32] = exp_h[i];
        return r;
    endfunction
    task automatic model_run(input int base12, input int cnt, input bit init);
        if (init) begin
            exp_h[0] = 32'h6a09e667; exp_h[1] = 32'hbb67ae85; exp_h[2] = 32'h3c6ef372;
            exp_h[3] = 32'ha54ff53a; exp_h[4] = 32'h510e527f; exp_h[5] = 32'h9b05688c;
            exp_h[6] = 32'h1f83d9ab; exp_h[7] = 32'h5be0cd19;
        end
        for (int b = 0; b <= cnt; b++)
            for (int i = 0; i < 8; i++)
                exp_h[i] = exp_h[i] + (msg_word(base12 + 64*b + 4*i) ^
                                       msg_word(base12 + 64*b + 4*(i+8)));
    endtask

    // ---------------- helpers
    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask
    task automatic wait_idle();
        logic [7:0] s;
        for (int n = 0; n < 20000; n++) begin
            rd(3'd1, s);
            if (!s[0]) return;
        end
    endtask
    task automatic set_base(input logic [7:0] hi, input logic [7:0] mid, input logic [7:0] lo);
        wr(3'd6, hi); wr(3'd4, mid); wr(3'd3, lo);
    endtask
    function automatic logic [31:0] mem_le(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction
    task automatic writeback_check(input string req);
        logic [255:0] got;
        set_base(8'h00, 8'h0F, 8'h00);
        wr(3'd0, 8'h04);
        wait_idle();
        for (int i = 0; i < 8; i++) got[255-32*i -: 32] = mem_le(12'hF00 + 4*i);
        chk(got == pack_h(), req, got, pack_h());
    endtask

    // vector: {cnt[28:25], init[24], hi[23:16], mid[15:8], lo[7:0]}
    localparam logic [28:0] VEC [4] = '{
        {4'd0,  1'b1, 8'h00, 8'h01, 8'h7F},
        {4'd3,  1'b0, 8'h00, 8'h02, 8'hC5},
        {4'd15, 1'b0, 8'h00, 8'h04, 8'h00},
        {4'd1,  1'b1, 8'hA5, 8'h09, 8'h40}
    };

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 8));
        for (int i = 0; i < 8; i++) exp_h[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(3'd0, d); chk(d == 8'h00, "R1 ctrl", 256'(d), 0);
        rd(3'd1, d); chk(d == 8'h00, "R1 status", 256'(d), 0);
        rd(3'd2, d); chk(d == 8'h00, "R1 count", 256'(d), 0);
        chk(irq == 1'b0, "R1 irq", 256'(irq), 0);
        writeback_check("R1 R7 zero state write-back");

        // R11: algorithm register and control readback
        wr(3'd5, 8'h00); wr(3'd5, 8'h3C);
        rd(3'd5, d); chk(d == 8'h3C, "R11 algo", 256'(d), 256'h3C);
        wr(3'd5, 8'h00);
        // R5: low base byte masking
        wr(3'd3, 8'h7F); rd(3'd3, d); chk(d == 8'h40, "R5 low byte mask", 256'(d), 256'h40);
        wr(3'd2, 8'h00);

        // vector table: R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < 4; v++) begin
            int cnt, base, rb, sb;
            bit init, ok;
            cnt  = int'(VEC[v][28:25]);
            init = VEC[v][24];
            base = int'({VEC[v][23:16], VEC[v][15:8], VEC[v][7:6], 6'b0});
            wr(3'd1, 8'h04);  // clear IS, IE off
            set_base(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
            wr(3'd2, 8'(cnt));
            rb = rd_n; sb = n_start;
            wr(3'd0, init ? 8'h03 : 8'h01);
            rd(3'd1, d); chk(d[0] == 1'b1, "R8 busy during op", 256'(d), 1);
            wait_idle();
            ok = (rd_n - rb) == (cnt + 1) * 16;
            for (int k = 0; k < (cnt + 1) * 16; k++)
                if (rd_log[(rb + k) % 2048] != 24'(base + 4 * k)) ok = 0;
            chk(ok, "R4 R5 read address sequence", 256'(rd_n - rb), 256'((cnt + 1) * 16));
            chk((n_start - sb) == cnt + 1, "R4 block count", 256'(n_start - sb), 256'(cnt + 1));
            if (init) model_run(0, -1, 1'b1);
            chk(st_log[sb % 64] == pack_h(), init ? "R2 initial state" : "R3 continued state",
                st_log[sb % 64], pack_h());
            model_run(base & 12'hFFF, cnt, 1'b0);
            rd(3'd1, d); chk(d[2] == 1'b1, "R9 status set on completion", 256'(d), 256'h04);
            writeback_check("R6 R7 digest write-back");
        end

        // R9: interrupt enable, write-0 keeps, write-1 clears
        wr(3'd1, 8'h0C);
        chk(irq == 1'b0, "R9 irq cleared", 256'(irq), 0);
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h04); wait_idle();
        chk(irq == 1'b1, "R9 irq raised", 256'(irq), 1);
        wr(3'd1, 8'h08);
        rd(3'd1, d); chk(d == 8'h0C, "R9 write 0 keeps flag", 256'(d), 256'h0C);
        wr(3'd1, 8'h04);
        rd(3'd1, d); chk(d == 8'h00 && irq == 1'b0, "R9 write 1 clears", 256'(d), 0);

        // R10: commands and parameter writes while busy are ignored
        begin
            int sb;
            set_base(8'h00, 8'h01, 8'h00);
            wr(3'd2, 8'h02);
            sb = n_start;
            wr(3'd0, 8'h03);
            wr(3'd2, 8'h00);
            wr(3'd4, 8'h05);
            wr(3'd0, 8'h03);
            wr(3'd0, 8'h04);
            wait_idle();
            chk((n_start - sb) == 3, "R10 busy start ignored", 256'(n_start - sb), 3);
            model_run(0, -1, 1'b1);
            model_run(12'h100, 2, 1'b0);
            writeback_check("R10 result unaffected");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule